// File: doc/BRIEF.md
# Tick-Synchronized Register Write Controller

This block stands between a fast bus and a slow timekeeping domain. A bus write aimed at one of the timekeeping registers is not applied at once. The block captures it in a single holding slot and applies it when the next slow tick arrives. While a captured write is still waiting, any further write to a timekeeping register is thrown away. Software learns the state of the slot from two flags in a status word. The busy flag shows that a write is held. The done flag shows that a held write has been applied.

The status word takes writes immediately. Each 1 written to the done flag's position clears that flag. The slow tick comes from one of two tick-enable inputs, each one cycle wide and already aligned to the bus clock. When the prescaler is on, the seconds tick is used. When it is off, the raw oscillator tick is used. Readback of a timekeeping register always returns the value already applied, never the held one. The applied values also leave the block on a flat output bus, for the counters that use them.

Top module: `tick_write_sync`

## Requirements
- R1: After reset every timekeeping register reads 0, the flat register output is 0, and the status word reads 0.
- R2: A write to a timekeeping address (address below NUM_SYNC_REGS) with no write held sets the busy flag (status bit 14) in the next cycle. Readback of that register keeps its old value while the write is held.
- R3: When a write is held and the selected slow tick is high at a clock edge, the held data is applied to its register at that edge. The busy flag clears and the done flag (status bit 15) sets, both visible in the following cycle.
- R4: With prescale_en at 1, only tick_sec applies a held write. A tick_osc pulse leaves it held.
- R5: With prescale_en at 0, only tick_osc applies a held write. A tick_sec pulse leaves it held.
- R6: A write to a timekeeping address while a write is held is discarded. Only the first write's data reaches the register, and the discarded writes change no other register.
- R7: A write to the status address (2**ADDR_W-1) clears the done flag when data bit 15 is 1 and leaves it alone when bit 15 is 0. The busy flag is never changed by a status write.
- R8: A status write takes effect in the very next cycle, even while a write is held, and it does not disturb the held write.
- R9: When a status write clearing done falls in the same cycle as an applying tick, the done flag ends up set.
- R10: Addresses that are neither timekeeping nor status read 0. Writes to them hold nothing and change nothing.
- R11: A slow tick in the same cycle as a write is accepted does not apply that write. The write waits for a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address for writes and readback |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W | Combinational readback of the addressed register |
| prescale_en | input | 1 | 1 selects tick_sec, 0 selects tick_osc as the slow tick |
| tick_sec | input | 1 | One-cycle pulse at the prescaled (seconds) rate |
| tick_osc | input | 1 | One-cycle pulse at the raw oscillator rate |
| sync_regs | output | NUM_SYNC_REGS*DATA_W | Applied values of all timekeeping registers, register 0 in the low bits |

## Verification
The bench builds the block with its default parameters: four timekeeping registers of 16 bits and a 3-bit address. This places the status word at address 7 and leaves addresses 4 to 6 unmapped, so the unmapped readback and write paths can be exercised. Both tick inputs are driven directly as single-cycle pulses. A second-long wait therefore shrinks to a few bus cycles, and each tick can be placed exactly on the cycle that matters. That makes it possible to test a tick in the same cycle as a write being accepted, and a tick in the same cycle as a status clear.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef int unsigned uint_t;

    localparam int STAT_W        = 16;
    localparam int STAT_DONE_BIT = 15;
    localparam int STAT_BUSY_BIT = 14;

    typedef enum logic [1:0] {
        ACC_SYNC     = 2'd0,
        ACC_STATUS   = 2'd1,
        ACC_UNMAPPED = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic done;
        logic busy;
    } tws_flags_t;

    function automatic acc_kind_e classify(input uint_t addr, input uint_t nregs,
                                           input uint_t stat_addr);
        if (addr == stat_addr)
            return ACC_STATUS;
        else if (addr < nregs)
            return ACC_SYNC;
        else
            return ACC_UNMAPPED;
    endfunction

    function automatic logic [STAT_W-1:0] status_word(input tws_flags_t f);
        logic [STAT_W-1:0] w;
        w                = '0;
        w[STAT_DONE_BIT] = f.done;
        w[STAT_BUSY_BIT] = f.busy;
        return w;
    endfunction

endpackage

// File: rtl/tws_tick_sel.sv
module tws_tick_sel (
    input  logic prescale_en,
    input  logic tick_sec,
    input  logic tick_osc,
    output logic slow_tick
);
    always_comb begin
        slow_tick = prescale_en ? tick_sec : tick_osc;
    end
endmodule

// File: rtl/tws_hold_slot.sv
module tws_hold_slot #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              slow_tick,
    output logic              pending,
    output logic              commit,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data
);
    always_comb begin
        commit = pending & slow_tick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (commit) begin
            pending <= 1'b0;
        end else if (take && !pending) begin
            pending   <= 1'b1;
            hold_addr <= wr_addr;
            hold_data <= wr_data;
        end
    end
endmodule

// File: rtl/tws_done_flag.sv
module tws_done_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic done
);
    always_ff @(posedge clk) begin
        if (rst)
            done <= 1'b0;
        else if (set_i)
            done <= 1'b1;
        else if (clr_i)
            done <= 1'b0;
    end
endmodule

// File: rtl/tws_commit_regs.sv
module tws_commit_regs #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         commit,
    input  logic [ADDR_W-1:0]            hold_addr,
    input  logic [DATA_W-1:0]            hold_data,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_flat[i*DATA_W +: DATA_W] <= '0;
            else if (commit && (hold_addr == ADDR_W'(i)))
                regs_flat[i*DATA_W +: DATA_W] <= hold_data;
        end
    end
endmodule

// File: rtl/tick_write_sync.sv
module tick_write_sync
    import tws_pkg::*;
#(
    parameter int NUM_SYNC_REGS = 4,
    parameter int DATA_W        = 16,
    parameter int ADDR_W        = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic                             bus_we,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic                             prescale_en,
    input  logic                             tick_sec,
    input  logic                             tick_osc,
    output logic [NUM_SYNC_REGS*DATA_W-1:0]  sync_regs
);
    localparam int STATUS_ADDR = (1 << ADDR_W) - 1;

    acc_kind_e          kind;
    logic               slow_tick;
    logic               pending;
    logic               commit;
    logic [ADDR_W-1:0]  hold_addr;
    logic [DATA_W-1:0]  hold_data;
    logic               done;
    logic               take_sync;
    logic               clr_done;
    tws_flags_t         flags;

    always_comb begin
        kind      = classify(uint_t'(bus_addr), uint_t'(NUM_SYNC_REGS), uint_t'(STATUS_ADDR));
        take_sync = bus_we && (kind == ACC_SYNC);
        clr_done  = bus_we && (kind == ACC_STATUS) && bus_wdata[STAT_DONE_BIT];
        flags     = '{done: done, busy: pending};
    end

    tws_tick_sel u_tick_sel (
        .prescale_en (prescale_en),
        .tick_sec    (tick_sec),
        .tick_osc    (tick_osc),
        .slow_tick   (slow_tick)
    );

    tws_hold_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .take      (take_sync),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .slow_tick (slow_tick),
        .pending   (pending),
        .commit    (commit),
        .hold_addr (hold_addr),
        .hold_data (hold_data)
    );

    tws_done_flag u_done (
        .clk   (clk),
        .rst   (rst),
        .set_i (commit),
        .clr_i (clr_done),
        .done  (done)
    );

    tws_commit_regs #(.NUM_REGS(NUM_SYNC_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .regs_flat (sync_regs)
    );

    always_comb begin
        bus_rdata = '0;
        case (kind)
            ACC_SYNC:   bus_rdata = sync_regs[int'(bus_addr)*DATA_W +: DATA_W];
            ACC_STATUS: bus_rdata[STAT_W-1:0] = status_word(flags);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tws_chk.sv
module tws_chk #(
    parameter int NUM_SYNC_REGS = 4,
    parameter int DATA_W        = 16,
    parameter int ADDR_W        = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic                            bus_we,
    input logic                            prescale_en,
    input logic                            tick_sec,
    input logic                            tick_osc,
    input logic                            slow_tick,
    input logic                            pending,
    input logic                            done,
    input logic [ADDR_W-1:0]               hold_addr,
    input logic [DATA_W-1:0]               hold_data,
    input logic [NUM_SYNC_REGS*DATA_W-1:0] sync_regs
);
    localparam int STATUS_ADDR = (1 << ADDR_W) - 1;

    logic is_sync, is_stat, is_unmapped;
    always_comb begin
        is_stat     = (int'(bus_addr) == STATUS_ADDR);
        is_sync     = !is_stat && (int'(bus_addr) < NUM_SYNC_REGS);
        is_unmapped = !is_stat && !is_sync;
    end

    p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_sync && !pending) |=> pending);

    p_idle_regs_r11: assert property (@(posedge clk) disable iff (rst)
        !pending |=> $stable(sync_regs));

    p_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (pending && slow_tick) |=> (!pending && done));

    p_sec_only_r4: assert property (@(posedge clk) disable iff (rst)
        (pending && prescale_en && !tick_sec) |=> pending);

    p_osc_sel_r5: assert property (@(posedge clk) disable iff (rst)
        (pending && !prescale_en && tick_osc) |=> !pending);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (pending && !slow_tick) |=> ($stable(hold_addr) && $stable(hold_data)));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_stat && bus_wdata[15] && !(pending && slow_tick)) |=> !done);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (pending && slow_tick && bus_we && is_stat) |=> done);

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_unmapped && !pending) |=> !pending);
endmodule

bind tick_write_sync tws_chk #(
    .NUM_SYNC_REGS (NUM_SYNC_REGS),
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .prescale_en (prescale_en),
    .tick_sec    (tick_sec),
    .tick_osc    (tick_osc),
    .slow_tick   (slow_tick),
    .pending     (pending),
    .done        (done),
    .hold_addr   (hold_addr),
    .hold_data   (hold_data),
    .sync_regs   (sync_regs)
);

// File: tb/tb_tick_write_sync.sv
module tb_tick_write_sync;
    localparam int NREG = 4;
    localparam int DW   = 16;
    localparam int AW   = 3;
    localparam logic [AW-1:0] STAT = 3'd7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [DW-1:0]   bus_rdata;
    logic            prescale_en = 1'b1;
    logic            tick_sec = 1'b0;
    logic            tick_osc = 1'b0;
    logic [NREG*DW-1:0] sync_regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tick_write_sync #(.NUM_SYNC_REGS(NREG), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .prescale_en(prescale_en),
        .tick_sec(tick_sec), .tick_osc(tick_osc), .sync_regs(sync_regs)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input bit sec);
        @(negedge clk);
        if (sec) tick_sec = 1'b1; else tick_osc = 1'b1;
        @(negedge clk);
        tick_sec = 1'b0; tick_osc = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        for (int i = 0; i < NREG; i++) begin
            rd(AW'(i), v);
            check("R1", "reg after reset", 64'(v), 64'h0);
        end
        rd(STAT, v);
        check("R1", "status after reset", 64'(v), 64'h0);
        check("R1", "sync_regs after reset", 64'(sync_regs), 64'h0);
    endtask

    task automatic t_basic;
        logic [DW-1:0] v;
        prescale_en = 1'b1;
        wr(3'd1, 16'hA5A5);
        rd(STAT, v);  check("R2", "busy after write", 64'(v), 64'h4000);
        rd(3'd1, v);  check("R2", "old value while held", 64'(v), 64'h0);
        pulse(0);
        rd(STAT, v);  check("R4", "osc tick ignored", 64'(v), 64'h4000);
        rd(3'd1, v);  check("R4", "reg unchanged by osc", 64'(v), 64'h0);
        pulse(1);
        rd(3'd1, v);  check("R3", "applied value", 64'(v), 64'hA5A5);
        rd(STAT, v);  check("R3", "done set busy clear", 64'(v), 64'h8000);
        wr(STAT, 16'h8000);
        rd(STAT, v);  check("R7", "done cleared", 64'(v), 64'h0);
    endtask

    task automatic t_osc_mode;
        logic [DW-1:0] v;
        prescale_en = 1'b0;
        wr(3'd2, 16'h1234);
        pulse(1);
        rd(STAT, v);  check("R5", "sec tick ignored", 64'(v), 64'h4000);
        pulse(0);
        rd(3'd2, v);  check("R5", "osc tick applies", 64'(v), 64'h1234);
        rd(STAT, v);  check("R5", "done after osc", 64'(v), 64'h8000);
        wr(STAT, 16'hFFFF);
        rd(STAT, v);  check("R7", "all-ones clears done", 64'(v), 64'h0);
        prescale_en = 1'b1;
    endtask

    task automatic t_drop;
        logic [DW-1:0] v;
        wr(3'd0, 16'h1111);
        wr(3'd3, 16'h2222);
        wr(3'd0, 16'h3333);
        pulse(1);
        rd(3'd0, v);  check("R6", "first write kept", 64'(v), 64'h1111);
        rd(3'd3, v);  check("R6", "dropped write absent", 64'(v), 64'h0);
        rd(STAT, v);  check("R6", "status after drop", 64'(v), 64'h8000);
        check("R6", "sync_regs word", 64'(sync_regs), 64'h0000_1234_A5A5_1111);
    endtask

    task automatic t_status_now;
        logic [DW-1:0] v;
        wr(3'd0, 16'h5555);
        rd(STAT, v);  check("R8", "busy and done", 64'(v), 64'hC000);
        wr(STAT, 16'h4000);
        rd(STAT, v);  check("R7", "busy bit write ignored", 64'(v), 64'hC000);
        wr(STAT, 16'h8000);
        rd(STAT, v);  check("R8", "clear while held", 64'(v), 64'h4000);
        pulse(1);
        rd(3'd0, v);  check("R8", "held write intact", 64'(v), 64'h5555);
    endtask

    task automatic t_set_priority;
        logic [DW-1:0] v;
        wr(3'd1, 16'h7777);
        @(negedge clk);
        bus_addr = STAT; bus_wdata = 16'h8000; bus_we = 1'b1; tick_sec = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_sec = 1'b0;
        rd(STAT, v);  check("R9", "set beats clear", 64'(v), 64'h8000);
        rd(3'd1, v);  check("R9", "value applied", 64'(v), 64'h7777);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] v;
        wr(STAT, 16'h8000);
        wr(3'd5, 16'hFFFF);
        rd(STAT, v);  check("R10", "no busy for unmapped", 64'(v), 64'h0);
        rd(3'd5, v);  check("R10", "unmapped reads 0", 64'(v), 64'h0);
        rd(3'd4, v);  check("R10", "addr 4 reads 0", 64'(v), 64'h0);
        pulse(1);
        check("R10", "regs unchanged", 64'(sync_regs), 64'h0000_1234_7777_5555);
    endtask

    task automatic t_same_cycle;
        logic [DW-1:0] v;
        @(negedge clk);
        bus_addr = 3'd2; bus_wdata = 16'hBEEF; bus_we = 1'b1; tick_sec = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_sec = 1'b0;
        rd(STAT, v);  check("R11", "still held", 64'(v), 64'h4000);
        rd(3'd2, v);  check("R11", "not applied yet", 64'(v), 64'h1234);
        pulse(1);
        rd(3'd2, v);  check("R11", "applied on later tick", 64'(v), 64'hBEEF);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_osc_mode();
        t_drop();
        t_status_now();
        t_set_priority();
        t_unmapped();
        t_same_cycle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end
endmodule